// File: doc/BRIEF.md
# Wake-on-LAN Magic Frame Detector

This block watches the byte stream of received Ethernet frames, one byte per clock, and raises a wake event when a frame carries the wake pattern for this station while wake mode is active. The wake pattern is a run of six 0xFF synchronisation bytes followed by sixteen back-to-back copies of the 48-bit station address. The pattern may start anywhere after the destination address field. The destination address can be required to equal the station address, or that filter can be relaxed so that any unicast, multicast or broadcast destination is accepted. The pattern in the payload is still required in both cases.

Wake mode is entered when the mode bit is set together with either the enable bit or the external power-good pin. A detected frame sets a sticky flag that the host clears by writing one. The flag drives an interrupt output, gated by a local enable bit and a global enable input. Hard reset, soft reset and stop each clear a different subset of the control state. Two write strobes share one data bus: one loads the configuration bits and the other loads the interrupt bits.

Top module: `wol_magic_det`

## Requirements
- R1: With relax off, a frame qualifies only if its first six bytes equal the station address, most significant byte first (byte 0 compared with `station_addr[47:40]`).
- R2: The effective relax control is `cfg relax bit OR relax_alt`. When it is 1, any destination address is accepted.
- R3: Scanning starts at frame byte 6. It needs six 0xFF bytes immediately followed by 16 consecutive station-address copies, each copy sent MSB first. The pattern may begin at any offset. A mismatch restarts the search, and a mismatching 0xFF byte counts as the first byte of a new sync run. Fewer than 16 copies never qualify.
- R4: `wake_active` = mode AND (enable OR `pwr_good`). While it is 0 at end of frame, no event and no flag set occur.
- R5: `rx_eof` is a strobe in a cycle with no data byte. A qualifying frame gives a one-cycle `wake_evt` pulse in the cycle after `rx_eof` only if `rx_good` is 1 with it. Frames ending with `rx_good` 0 are dropped silently.
- R6: `irq_flag` sets together with `wake_evt`. An `int_wr` with `wr_data[4]`=1 clears it, and `wr_data[4]`=0 leaves it unchanged. A set in the same cycle as a clear wins.
- R7: `irq` = `irq_flag` AND interrupt-enable bit AND `glob_ie`.
- R8: `irq_flag` is cleared by hard reset, soft reset or stop. Enable, mode and relax are cleared by hard or soft reset and are kept across stop. The interrupt-enable bit is cleared only by hard reset.
- R9: `cfg_wr` loads enable, mode and relax from `wr_data[0]`, `wr_data[1]` and `wr_data[2]`. `int_wr` loads the interrupt-enable bit from `wr_data[3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_hard | input | 1 | Hard reset, synchronous, active high |
| rst_soft | input | 1 | Soft reset, synchronous, active high |
| stop | input | 1 | Stop request, clears the interrupt flag |
| rx_valid | input | 1 | A received byte is present |
| rx_sof | input | 1 | Marks the first byte of a frame (with rx_valid) |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | End-of-frame strobe, in a cycle without a byte |
| rx_good | input | 1 | Frame passed its integrity check, valid with rx_eof |
| station_addr | input | 48 | Station address |
| pwr_good | input | 1 | Power-good pin, an alternative to the enable bit |
| relax_alt | input | 1 | Second relax control, ORed with the register bit |
| glob_ie | input | 1 | Global interrupt enable |
| cfg_wr | input | 1 | Write strobe for the configuration bits |
| int_wr | input | 1 | Write strobe for the interrupt bits |
| wr_data | input | 5 | Write data, fields as in R6 and R9 |
| wake_active | output | 1 | Wake mode is active |
| wake_evt | output | 1 | One-cycle pulse on a detected wake frame |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
`wake_evt` and `irq_flag` change at the clock edge that samples `rx_eof`, so the bench reads them at the next falling edge. `irq` and `wake_active` are combinational from registered bits and inputs, so they are read one falling edge after the write or reset pulse that changed them. Every input is driven at a falling edge and every output is read at a falling edge, which keeps each sample half a period away from the edge that updates it. The set-versus-clear case places the clear write in exactly the cycle of `rx_eof`.

// File: rtl/wol_pkg.sv
package wol_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
   // field positions on the shared write-data bus
   localparam int F_EN    = 0;
   localparam int F_MODE  = 1;
   localparam int F_RELAX = 2;
   localparam int F_IE    = 3;
   localparam int F_CLR   = 4;
   localparam int WR_W    = 5;
endpackage

// File: rtl/wol_addr_filter.sv
module wol_addr_filter
   import wol_pkg::*;
#(
   parameter int ADDR_BYTES = 6
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  rx_valid,
   input  logic  rx_sof,
   input  byte_t rx_byte,
   input  byte_t addr_b [ADDR_BYTES],
   input  logic  relax,
   output logic  payload_vld,
   output logic  dest_ok
);
   localparam int IW = $clog2(ADDR_BYTES + 1);

   logic [IW-1:0] hdr_idx_q, cur_idx;
   logic          match_q, is_hdr, byte_eq;

   always_comb begin
      cur_idx = rx_sof ? '0 : hdr_idx_q;
      is_hdr  = rx_valid && (cur_idx < IW'(ADDR_BYTES));
      byte_eq = is_hdr && (rx_byte == addr_b[cur_idx]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hdr_idx_q <= IW'(ADDR_BYTES);
         match_q   <= 1'b0;
      end else if (is_hdr) begin
         hdr_idx_q <= cur_idx + 1'b1;
         match_q   <= (rx_sof ? 1'b1 : match_q) && byte_eq;
      end
   end

   assign payload_vld = rx_valid && !is_hdr;
   assign dest_ok     = relax || match_q;

   // a header byte never reaches the payload scanner (R3)
   p_hdr_not_payload_r3: assert property (@(posedge clk) disable iff (rst)
      (rx_valid && rx_sof) |-> !payload_vld);
endmodule

// File: rtl/wol_pattern_scan.sv
module wol_pattern_scan
   import wol_pkg::*;
#(
   parameter int    ADDR_BYTES = 6,
   parameter int    SYNC_LEN   = 6,
   parameter int    COPIES     = 16,
   parameter byte_t SYNC_BYTE  = 8'hFF
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  rx_sof,
   input  logic  byte_vld,
   input  byte_t rx_byte,
   input  byte_t addr_b [ADDR_BYTES],
   output logic  found
);
   localparam int SW = $clog2(SYNC_LEN + 1);
   localparam int PW = $clog2(ADDR_BYTES);
   localparam int CW = $clog2(COPIES);

   if (ADDR_BYTES < 2) begin : g_bad_addr
      $error("ADDR_BYTES must be at least 2");
   end
   if (COPIES < 2) begin : g_bad_copies
      $error("COPIES must be at least 2");
   end
   if (SYNC_LEN < 1) begin : g_bad_sync
      $error("SYNC_LEN must be at least 1");
   end

   logic [SW-1:0] sync_q, sync_d;
   logic [PW-1:0] pos_q, pos_d;
   logic [CW-1:0] copy_q, copy_d;
   logic          found_q, found_d;
   logic          is_sync, sync_full, fresh;
   byte_t         expect_b;

   always_comb begin
      expect_b  = addr_b[pos_q];
      is_sync   = (rx_byte == SYNC_BYTE);
      sync_full = (sync_q == SW'(SYNC_LEN));
      fresh     = (pos_q == '0) && (copy_q == '0);
      sync_d    = sync_q;
      pos_d     = pos_q;
      copy_d    = copy_q;
      found_d   = found_q;
      if (rx_sof) begin
         sync_d  = '0;
         pos_d   = '0;
         copy_d  = '0;
         found_d = 1'b0;
      end else if (byte_vld && !found_q) begin
         if (!sync_full) begin
            sync_d = is_sync ? sync_q + 1'b1 : '0;
         end else if (rx_byte == expect_b) begin
            if (pos_q == PW'(ADDR_BYTES - 1)) begin
               pos_d = '0;
               if (copy_q == CW'(COPIES - 1)) found_d = 1'b1;
               else                           copy_d  = copy_q + 1'b1;
            end else begin
               pos_d = pos_q + 1'b1;
            end
         end else begin
            pos_d  = '0;
            copy_d = '0;
            if (!is_sync)   sync_d = '0;
            else if (fresh) sync_d = sync_q;
            else            sync_d = SW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q  <= '0;
         pos_q   <= '0;
         copy_q  <= '0;
         found_q <= 1'b0;
      end else begin
         sync_q  <= sync_d;
         pos_q   <= pos_d;
         copy_q  <= copy_d;
         found_q <= found_d;
      end
   end

   assign found = found_q;

   // completion only ever follows a scanned payload byte (R3)
   p_found_after_byte_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(found_q) |-> $past(byte_vld));
   // the sync counter stays within its run length (R3)
   p_sync_bound_r3: assert property (@(posedge clk) disable iff (rst)
      sync_q <= SW'(SYNC_LEN));
endmodule

// File: rtl/wol_ctrl_regs.sv
module wol_ctrl_regs
   import wol_pkg::*;
(
   input  logic            clk,
   input  logic            rst_hard,
   input  logic            rst_soft,
   input  logic            stop,
   input  logic            cfg_wr,
   input  logic            int_wr,
   input  logic [WR_W-1:0] wr_data,
   input  logic            frame_ok,
   input  logic            pwr_good,
   input  logic            relax_alt,
   input  logic            glob_ie,
   output logic            relax_eff,
   output logic            wake_active,
   output logic            wake_evt,
   output logic            irq_flag,
   output logic            irq
);
   logic en_q, mode_q, relax_q, ie_q, flag_q, evt_q, hit;

   assign wake_active = mode_q && (en_q || pwr_good);
   assign relax_eff   = relax_q || relax_alt;
   assign hit         = frame_ok && wake_active;

   always_ff @(posedge clk) begin
      if (rst_hard || rst_soft) begin
         en_q    <= 1'b0;
         mode_q  <= 1'b0;
         relax_q <= 1'b0;
      end else if (cfg_wr) begin
         en_q    <= wr_data[F_EN];
         mode_q  <= wr_data[F_MODE];
         relax_q <= wr_data[F_RELAX];
      end
   end

   always_ff @(posedge clk) begin
      if (rst_hard)    ie_q <= 1'b0;
      else if (int_wr) ie_q <= wr_data[F_IE];
   end

   always_ff @(posedge clk) begin
      if (rst_hard || rst_soft || stop)     flag_q <= 1'b0;
      else if (hit)                         flag_q <= 1'b1;
      else if (int_wr && wr_data[F_CLR])    flag_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst_hard || rst_soft) evt_q <= 1'b0;
      else                      evt_q <= hit;
   end

   assign wake_evt = evt_q;
   assign irq_flag = flag_q;
   assign irq      = flag_q && ie_q && glob_ie;

   // flag only rises on a detected frame (R6)
   p_flag_cause_r6: assert property (@(posedge clk) disable iff (rst_hard || rst_soft)
      $rose(flag_q) |-> $past(hit));
   // write-one-to-clear without a competing set empties the flag (R6)
   p_w1c_r6: assert property (@(posedge clk) disable iff (rst_hard || rst_soft)
      (int_wr && wr_data[F_CLR] && !hit) |=> !flag_q);
   // stop empties the flag (R8)
   p_stop_clears_r8: assert property (@(posedge clk) disable iff (rst_hard || rst_soft)
      stop |=> !flag_q);
   // soft reset leaves the interrupt enable alone (R8)
   p_ie_keeps_r8: assert property (@(posedge clk) disable iff (rst_hard)
      (rst_soft && !int_wr) |=> (ie_q == $past(ie_q)));
endmodule

// File: rtl/wol_magic_det.sv
module wol_magic_det
   import wol_pkg::*;
#(
   parameter int    ADDR_BYTES = 6,
   parameter int    SYNC_LEN   = 6,
   parameter int    COPIES     = 16,
   parameter byte_t SYNC_BYTE  = 8'hFF
) (
   input  logic                       clk,
   input  logic                       rst_hard,
   input  logic                       rst_soft,
   input  logic                       stop,
   input  logic                       rx_valid,
   input  logic                       rx_sof,
   input  logic [7:0]                 rx_byte,
   input  logic                       rx_eof,
   input  logic                       rx_good,
   input  logic [ADDR_BYTES*8-1:0]    station_addr,
   input  logic                       pwr_good,
   input  logic                       relax_alt,
   input  logic                       glob_ie,
   input  logic                       cfg_wr,
   input  logic                       int_wr,
   input  logic [4:0]                 wr_data,
   output logic                       wake_active,
   output logic                       wake_evt,
   output logic                       irq_flag,
   output logic                       irq
);
   localparam int ADDR_W = ADDR_BYTES * BYTE_W;

   if (WR_W != 5) begin : g_bad_wr
      $error("write bus width mismatch");
   end

   byte_t addr_b [ADDR_BYTES];
   logic  rst, payload_vld, dest_ok, found, relax_eff, frame_ok;

   assign rst = rst_hard || rst_soft;

   for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_split
      assign addr_b[g] = station_addr[ADDR_W-1-g*BYTE_W -: BYTE_W];
   end

   wol_addr_filter #(.ADDR_BYTES(ADDR_BYTES)) u_filt (
      .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
      .rx_byte(rx_byte), .addr_b(addr_b), .relax(relax_eff),
      .payload_vld(payload_vld), .dest_ok(dest_ok)
   );

   wol_pattern_scan #(
      .ADDR_BYTES(ADDR_BYTES), .SYNC_LEN(SYNC_LEN),
      .COPIES(COPIES), .SYNC_BYTE(SYNC_BYTE)
   ) u_scan (
      .clk(clk), .rst(rst), .rx_sof(rx_sof), .byte_vld(payload_vld),
      .rx_byte(rx_byte), .addr_b(addr_b), .found(found)
   );

   assign frame_ok = rx_eof && rx_good && found && dest_ok;

   wol_ctrl_regs u_regs (
      .clk(clk), .rst_hard(rst_hard), .rst_soft(rst_soft), .stop(stop),
      .cfg_wr(cfg_wr), .int_wr(int_wr), .wr_data(wr_data),
      .frame_ok(frame_ok), .pwr_good(pwr_good), .relax_alt(relax_alt),
      .glob_ie(glob_ie), .relax_eff(relax_eff), .wake_active(wake_active),
      .wake_evt(wake_evt), .irq_flag(irq_flag), .irq(irq)
   );

   // an event always follows a good end of frame (R5)
   p_evt_needs_good_r5: assert property (@(posedge clk) disable iff (rst)
      wake_evt |-> $past(rx_eof && rx_good));
   // an event is a single-cycle pulse (R5)
   p_evt_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      wake_evt |=> !wake_evt);
endmodule

// File: tb/tb_wol_magic_det.sv
`timescale 1ns/1ps
module tb_wol_magic_det;
   logic        clk = 1'b0;
   logic        rst_hard = 1'b1, rst_soft = 1'b0, stop = 1'b0;
   logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic [47:0] station_addr = 48'h02A1B2C3D4E5;
   logic        pwr_good = 1'b0, relax_alt = 1'b0, glob_ie = 1'b1;
   logic        cfg_wr = 1'b0, int_wr = 1'b0;
   logic [4:0]  wr_data = '0;
   logic        wake_active, wake_evt, irq_flag, irq;

   int total = 0, bad = 0;
   bit done = 0;
   logic [7:0] fb [0:255];
   int  flen;
   bit  evt_seen;
   bit  cur_ie = 0;

   always #2.5 clk = ~clk;

   wol_magic_det dut (
      .clk(clk), .rst_hard(rst_hard), .rst_soft(rst_soft), .stop(stop),
      .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_byte(rx_byte),
      .rx_eof(rx_eof), .rx_good(rx_good), .station_addr(station_addr),
      .pwr_good(pwr_good), .relax_alt(relax_alt), .glob_ie(glob_ie),
      .cfg_wr(cfg_wr), .int_wr(int_wr), .wr_data(wr_data),
      .wake_active(wake_active), .wake_evt(wake_evt),
      .irq_flag(irq_flag), .irq(irq)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b);
      fb[flen] = b;
      flen++;
   endtask

   task automatic push_copies(input int n);
      for (int c = 0; c < n; c++)
         for (int k = 0; k < 6; k++) push(station_addr[47-8*k -: 8]);
   endtask

   task automatic push_ff(input int n);
      for (int k = 0; k < n; k++) push(8'hFF);
   endtask

   // kind 0: plain pattern, 1: offset with false starts, 2: 15 copies
   task automatic send_frame(input logic [47:0] dst, input int kind,
                             input bit good, input bit clr_at_eof);
      flen = 0;
      for (int k = 0; k < 6; k++) push(dst[47-8*k -: 8]);
      for (int k = 0; k < 6; k++) push(8'h10 + 8'(k));
      case (kind)
         0: begin push_ff(6); push_copies(16); end
         1: begin
            push(8'h33); push(8'h44); push(8'h55);
            push_ff(3); push(8'h00);
            push_ff(6); push_copies(5);
            push_ff(6); push_copies(16);
            push(8'h77);
         end
         default: begin push_ff(6); push_copies(15); push(8'h00); end
      endcase
      for (int i = 0; i < flen; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = fb[i];
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b1; rx_good = good;
      if (clr_at_eof) begin
         int_wr = 1'b1; wr_data = {1'b1, cur_ie, 3'b000};
      end
      @(negedge clk);
      rx_eof = 1'b0; rx_good = 1'b0; int_wr = 1'b0;
      evt_seen = wake_evt;
   endtask

   task automatic cfg(input bit en, input bit mode, input bit relax);
      @(negedge clk);
      cfg_wr = 1'b1; wr_data = {2'b00, relax, mode, en};
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic intw(input bit ie, input bit clr);
      cur_ie = ie;
      @(negedge clk);
      int_wr = 1'b1; wr_data = {clr, ie, 3'b000};
      @(negedge clk);
      int_wr = 1'b0;
   endtask

   task automatic t_reset;
      chk("R8 reset flag", irq_flag, 1'b0);
      chk("R7 reset irq", irq, 1'b0);
      chk("R4 reset wake_active", wake_active, 1'b0);
      chk("R5 reset evt", wake_evt, 1'b0);
   endtask

   task automatic t_basic;
      cfg(1, 1, 0); intw(1, 0);
      chk("R9 R4 wake_active after cfg", wake_active, 1'b1);
      send_frame(station_addr, 0, 1, 0);
      chk("R1 R5 event on matching frame", evt_seen, 1'b1);
      chk("R6 flag set", irq_flag, 1'b1);
      chk("R7 irq asserted", irq, 1'b1);
      @(negedge clk);
      chk("R5 pulse is one cycle", wake_evt, 1'b0);
   endtask

   task automatic t_w1c;
      intw(1, 0);
      chk("R6 write 0 keeps flag", irq_flag, 1'b1);
      intw(1, 1);
      chk("R6 write 1 clears flag", irq_flag, 1'b0);
   endtask

   task automatic t_filter;
      send_frame(48'h02A1B2C3D4E6, 0, 1, 0);
      chk("R1 wrong destination rejected", evt_seen, 1'b0);
      chk("R1 flag stays clear", irq_flag, 1'b0);
      relax_alt = 1'b1;
      send_frame(48'h02A1B2C3D4E6, 0, 1, 0);
      chk("R2 relax_alt accepts unicast", evt_seen, 1'b1);
      relax_alt = 1'b0; intw(1, 1);
      cfg(1, 1, 1);
      send_frame(48'hFFFFFFFFFFFF, 0, 1, 0);
      chk("R2 relax bit accepts broadcast", evt_seen, 1'b1);
      intw(1, 1);
      send_frame(48'h0300AABBCCDD, 0, 1, 0);
      chk("R2 relax bit accepts multicast", evt_seen, 1'b1);
      intw(1, 1);
      cfg(1, 1, 0);
   endtask

   task automatic t_pattern;
      send_frame(station_addr, 1, 1, 0);
      chk("R3 offset pattern after false starts", evt_seen, 1'b1);
      intw(1, 1);
      send_frame(station_addr, 2, 1, 0);
      chk("R3 fifteen copies rejected", evt_seen, 1'b0);
      chk("R3 flag clear on short pattern", irq_flag, 1'b0);
      send_frame(station_addr, 0, 0, 0);
      chk("R5 bad frame dropped", evt_seen, 1'b0);
      chk("R5 flag clear on bad frame", irq_flag, 1'b0);
   endtask

   task automatic t_mode;
      cfg(0, 1, 0);
      chk("R4 mode without enable or power-good", wake_active, 1'b0);
      send_frame(station_addr, 0, 1, 0);
      chk("R4 no event outside wake mode", evt_seen, 1'b0);
      pwr_good = 1'b1;
      @(negedge clk);
      chk("R4 power-good enters wake mode", wake_active, 1'b1);
      send_frame(station_addr, 0, 1, 0);
      chk("R4 event via power-good", evt_seen, 1'b1);
      cfg(1, 0, 0);
      chk("R4 enable without mode", wake_active, 1'b0);
      pwr_good = 1'b0;
      intw(1, 1);
      cfg(1, 1, 0);
   endtask

   task automatic t_irq_gate;
      send_frame(station_addr, 0, 1, 0);
      glob_ie = 1'b0;
      @(negedge clk);
      chk("R7 global enable gates irq", irq, 1'b0);
      glob_ie = 1'b1;
      intw(0, 0);
      chk("R7 local enable gates irq", irq, 1'b0);
      intw(1, 0);
      chk("R7 irq back with both enables", irq, 1'b1);
      intw(1, 1);
   endtask

   task automatic t_set_wins;
      send_frame(station_addr, 0, 1, 1);
      chk("R6 set wins over same-cycle clear", irq_flag, 1'b1);
   endtask

   task automatic t_resets;
      @(negedge clk); stop = 1'b1;
      @(negedge clk); stop = 1'b0;
      chk("R8 stop clears flag", irq_flag, 1'b0);
      chk("R8 stop keeps mode and enable", wake_active, 1'b1);
      send_frame(station_addr, 0, 1, 0);
      chk("R8 stop keeps irq enable", irq, 1'b1);
      @(negedge clk); rst_soft = 1'b1;
      @(negedge clk); rst_soft = 1'b0;
      chk("R8 soft reset clears flag", irq_flag, 1'b0);
      chk("R8 soft reset clears mode", wake_active, 1'b0);
      cfg(1, 1, 0);
      send_frame(station_addr, 0, 1, 0);
      chk("R8 soft reset keeps irq enable", irq, 1'b1);
      @(negedge clk); rst_hard = 1'b1;
      @(negedge clk); rst_hard = 1'b0;
      chk("R8 hard reset clears flag", irq_flag, 1'b0);
      cfg(1, 1, 0);
      send_frame(station_addr, 0, 1, 0);
      chk("R8 hard reset flag sets again", irq_flag, 1'b1);
      chk("R8 hard reset cleared irq enable", irq, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_hard = 1'b0;
      @(negedge clk);
      t_reset;
      t_basic;
      t_w1c;
      t_filter;
      t_pattern;
      t_mode;
      t_irq_gate;
      t_set_wins;
      t_resets;
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule